// File: doc/BRIEF.md
# Rate and Signal-Loss Setting Selector

This block picks the two settings that a receive front end needs for its current line rate: a filter-bandwidth code and a signal-loss threshold code. Two rate-select pins name one of four slots. Each slot has one bandwidth override register and one threshold override register. The top bit of each override register decides whether that register's own field is used or a built-in default code for that slot is used.

The pins are asynchronous, so each passes through a two-flop synchronizer. The selected codes, together with a range flag taken from the control byte, are registered and driven on output ports. They are also reflected into two read-only status bytes, zero-extended to eight bits. After reset the pins read as if they were left floating (high, low), so the block starts on the last slot. It shows that slot's default codes until the first clock edge after reset.

Top module: `rate_los_selector`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs hold the default bandwidth and threshold codes of slot D, and the range flag is 0. This holds whatever the override registers contain.
- R2: The pin pattern {rate_hi_pin, rate_lo_pin} selects a slot as follows: 00 selects slot A (index 0), 01 selects B (index 1), 11 selects C (index 2) and 10 selects D (index 3).
- R3: When bit 7 of the selected slot's bandwidth register is 1, the bandwidth output equals bits 3..0 of that register.
- R4: When bit 7 of the selected slot's register is 0, the output is that slot's default code, and the register's low bits have no effect.
- R5: When bit 7 of the selected slot's threshold register is 1, the threshold output equals bits 6..0 of that register. Otherwise it is the slot's default threshold code.
- R6: The range flag equals bit 2 of the control byte, and the other control bits have no effect.
- R7: The bandwidth status byte is {4'b0, bandwidth code} and the threshold status byte is {1'b0, threshold code}.
- R8: A register change shows at the outputs after one rising edge. A pin change shows after three rising edges and not before.
- R9: The override registers of slots that are not selected have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_hi_pin | input | 1 | Upper rate-select pin, asynchronous |
| rate_lo_pin | input | 1 | Lower rate-select pin, asynchronous |
| ctl_byte | input | 8 | Control byte; bit 2 is the threshold range |
| bw_regs | input | 32 | Four bandwidth override bytes, slot A in bits 7..0 |
| thr_regs | input | 32 | Four threshold override bytes, slot A in bits 7..0 |
| bw_code | output | 4 | Selected bandwidth code |
| thr_code | output | 7 | Selected threshold code |
| thr_range | output | 1 | Threshold range flag |
| stat_bw_byte | output | 8 | Read-only status byte carrying the bandwidth code |
| stat_thr_byte | output | 8 | Read-only status byte carrying the threshold code |

## Verification
The assertions check on every cycle that each synchronizer output repeats its pin two cycles later, that the range flag follows the control bit, and that an enabled override field of the active slot reaches the output one cycle later. They also check that the outputs hold still while the synchronized slot and the registers hold still. Only the bench scenarios can show the pin-to-slot mapping against independent expectations, the default codes per slot, the exact three-edge pin latency, reset behaviour with overrides already enabled, and that registers of unselected slots are ignored.

// File: rtl/rls_pkg.sv
package rls_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = 2;
    localparam int REG_W     = 8;
    localparam int SEL_BIT   = REG_W - 1;

    // slot index for a pin pattern {hi, lo}; gray order of the pins
    function automatic logic [SLOT_W-1:0] pins_to_slot(input logic hi, input logic lo);
        logic [SLOT_W-1:0] s;
        case ({hi, lo})
            2'b00:   s = 2'd0;
            2'b01:   s = 2'd1;
            2'b11:   s = 2'd2;
            default: s = 2'd3;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/rls_pin_sync.sv
module rls_pin_sync #(
    parameter int          N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] pin_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= RST_VAL[b];
                sync_q[b] <= RST_VAL[b];
            end else begin
                meta_q[b] <= pin_i[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign pin_o = sync_q;

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (pin_o == $past(pin_i, 2)));
endmodule

// File: rtl/rls_field_pick.sv
module rls_field_pick
    import rls_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [NUM_SLOTS-1:0][REG_W-1:0] regs_i,
    input  logic [NUM_SLOTS-1:0][W-1:0]     defs_i,
    input  logic [SLOT_W-1:0]               slot_i,
    output logic [W-1:0]                    code_o
);
    logic [NUM_SLOTS-1:0][W-1:0] cand;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign cand[s] = regs_i[s][SEL_BIT] ? regs_i[s][W-1:0] : defs_i[s];
    end

    assign code_o = cand[slot_i];
endmodule

// File: rtl/rate_los_selector.sv
module rate_los_selector
    import rls_pkg::*;
#(
    parameter int BW_W  = 4,
    parameter int THR_W = 7,
    parameter logic [NUM_SLOTS-1:0][BW_W-1:0]  BW_DEF  = {4'd12, 4'd9, 4'd6, 4'd1},
    parameter logic [NUM_SLOTS-1:0][THR_W-1:0] THR_DEF = {7'd40, 7'd40, 7'd20, 7'd10},
    parameter int RANGE_BIT = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rate_hi_pin,
    input  logic                           rate_lo_pin,
    input  logic [REG_W-1:0]               ctl_byte,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0] bw_regs,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0] thr_regs,
    output logic [BW_W-1:0]                bw_code,
    output logic [THR_W-1:0]               thr_code,
    output logic                           thr_range,
    output logic [REG_W-1:0]               stat_bw_byte,
    output logic [REG_W-1:0]               stat_thr_byte
);
    localparam logic [SLOT_W-1:0] RST_SLOT = 2'd3;
    localparam int BW_PAD  = REG_W - BW_W;
    localparam int THR_PAD = REG_W - THR_W;

    typedef struct packed {
        logic [BW_W-1:0]  bw;
        logic [THR_W-1:0] thr;
        logic             rng;
        logic             seen;
    } sel_state_t;

    logic [1:0]        pins_s;
    logic [SLOT_W-1:0] slot_w;
    logic [BW_W-1:0]   bw_pick;
    logic [THR_W-1:0]  thr_pick;
    sel_state_t        st_d, st_q;

    rls_pin_sync #(.N(2), .RST_VAL(2'b10)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({rate_hi_pin, rate_lo_pin}),
        .pin_o (pins_s)
    );

    assign slot_w = pins_to_slot(pins_s[1], pins_s[0]);

    rls_field_pick #(.W(BW_W)) i_bw_pick (
        .regs_i (bw_regs),
        .defs_i (BW_DEF),
        .slot_i (slot_w),
        .code_o (bw_pick)
    );

    rls_field_pick #(.W(THR_W)) i_thr_pick (
        .regs_i (thr_regs),
        .defs_i (THR_DEF),
        .slot_i (slot_w),
        .code_o (thr_pick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bw   = bw_pick;
        st_d.thr  = thr_pick;
        st_d.rng  = ctl_byte[RANGE_BIT];
        st_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bw   <= BW_DEF[RST_SLOT];
            st_q.thr  <= THR_DEF[RST_SLOT];
            st_q.rng  <= 1'b0;
            st_q.seen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bw_code       = st_q.bw;
    assign thr_code      = st_q.thr;
    assign thr_range     = st_q.rng;
    assign stat_bw_byte  = {{BW_PAD{1'b0}}, st_q.bw};
    assign stat_thr_byte = {{THR_PAD{1'b0}}, st_q.thr};

    logic [REG_W-1:0] act_bw_reg, act_thr_reg;
    assign act_bw_reg  = bw_regs[slot_w];
    assign act_thr_reg = thr_regs[slot_w];

    // R3
    bw_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_bw_reg[SEL_BIT] |=> (bw_code == $past(act_bw_reg[BW_W-1:0])));

    // R5
    thr_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_thr_reg[SEL_BIT] |=> (thr_code == $past(act_thr_reg[THR_W-1:0])));

    // R6
    range_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (thr_range == $past(ctl_byte[RANGE_BIT])));

    // R9
    hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seen && $stable(slot_w) && $stable(act_bw_reg) && $stable(act_thr_reg))
        |=> ($stable(bw_code) && $stable(thr_code)));
endmodule

// File: tb/test_rate_los_selector.sv
module test_rate_los_selector;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0][3:0] TB_BW_DEF  = {4'd12, 4'd9, 4'd6, 4'd1};
    localparam logic [3:0][6:0] TB_THR_DEF = {7'd40, 7'd40, 7'd20, 7'd10};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi, lo;
    logic [7:0] ctl;
    logic [3:0][7:0] bwr, thrr;
    logic [3:0] bw_code;
    logic [6:0] thr_code;
    logic thr_range;
    logic [7:0] sbw, sthr;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_los_selector #(.BW_DEF(TB_BW_DEF), .THR_DEF(TB_THR_DEF)) i_rate_los_selector (
        .clk(clk), .rst_n(rst_n), .rate_hi_pin(hi), .rate_lo_pin(lo),
        .ctl_byte(ctl), .bw_regs(bwr), .thr_regs(thrr),
        .bw_code(bw_code), .thr_code(thr_code), .thr_range(thr_range),
        .stat_bw_byte(sbw), .stat_thr_byte(sthr)
    );

    function automatic int slot_of(input logic h, input logic l);
        if (!h && !l) return 0;
        if (!h &&  l) return 1;
        if ( h &&  l) return 2;
        return 3;
    endfunction

    function automatic logic [3:0] exp_bw(input int s);
        return bwr[s][7] ? bwr[s][3:0] : TB_BW_DEF[s];
    endfunction

    function automatic logic [6:0] exp_thr(input int s);
        return thrr[s][7] ? thrr[s][6:0] : TB_THR_DEF[s];
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic check_all(input string tag);
        int s;
        s = slot_of(hi, lo);
        chk({tag, " R2 bw"}, bw_code, exp_bw(s));
        chk({tag, " R5 thr"}, thr_code, exp_thr(s));
        chk({tag, " R6 range"}, thr_range, ctl[2]);
        chk({tag, " R7 stat bw"}, sbw, {4'b0, exp_bw(s)});
        chk({tag, " R7 stat thr"}, sthr, {1'b0, exp_thr(s)});
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        hi = 1'b0; lo = 1'b0; ctl = 8'hFF;
        bwr  = {8'h83, 8'h83, 8'h83, 8'h83};
        thrr = {8'hFF, 8'hFF, 8'hFF, 8'hFF};
        step(3);
        // R1: defaults of slot D during reset, even with overrides enabled
        chk("R1 bw in reset", bw_code, TB_BW_DEF[3]);
        chk("R1 thr in reset", thr_code, TB_THR_DEF[3]);
        chk("R1 range in reset", thr_range, 0);
        rst_n = 1'b1;
        #1;
        chk("R1 bw after release", bw_code, TB_BW_DEF[3]);
        chk("R1 stat thr after release", sthr, {1'b0, TB_THR_DEF[3]});
        // first edge: slot D from synchronizer reset state, overrides enabled
        step(1);
        chk("R1 slot D override bw", bw_code, 3);
        chk("R1 slot D override thr", thr_code, 127);

        // R4: defaults per slot with override bits clear, junk low bits
        bwr  = {8'h7F, 8'h7F, 8'h7F, 8'h7F};
        thrr = {8'h7F, 8'h7F, 8'h7F, 8'h7F};
        ctl  = 8'h00;
        for (int p = 0; p < 4; p++) begin
            hi = p[1]; lo = p[0];
            step(4);
            chk("R4 default bw", bw_code, TB_BW_DEF[slot_of(hi, lo)]);
            chk("R4 default thr", thr_code, TB_THR_DEF[slot_of(hi, lo)]);
        end

        // R2/R3: distinct override per slot identifies mapping
        bwr  = {8'h84, 8'h83, 8'h82, 8'h81};
        thrr = {8'hC4, 8'hC3, 8'hC2, 8'hC1};
        hi = 0; lo = 0; step(4); chk("R2 pins00 R3", bw_code, 1);
        hi = 0; lo = 1; step(4); chk("R2 pins01 R3", bw_code, 2);
        hi = 1; lo = 1; step(4); chk("R2 pins11 R3", bw_code, 3);
        hi = 1; lo = 0; step(4); chk("R2 pins10 R3", bw_code, 4);
        chk("R5 slot D thr field", thr_code, 7'h44);

        // R8: register latency one edge
        bwr[3] = 8'h8A;
        #1; chk("R8 reg before edge", bw_code, 4);
        step(1); chk("R8 reg after edge", bw_code, 10);

        // R8: pin latency three edges
        hi = 0; lo = 0;
        step(1); chk("R8 pin edge1", bw_code, 10);
        step(1); chk("R8 pin edge2", bw_code, 10);
        step(1); chk("R8 pin edge3", bw_code, 1);

        // R9: unselected slots ignored (slot A active)
        bwr[1] = 8'h8F; bwr[2] = 8'h0E; bwr[3] = 8'h85;
        thrr[1] = 8'h80; thrr[3] = 8'h00;
        step(2);
        chk("R9 bw", bw_code, 1);
        chk("R9 thr", thr_code, 7'h41);

        // R6: only bit 2 of control matters
        ctl = 8'hFB; step(1); chk("R6 other bits", thr_range, 0);
        ctl = 8'h04; step(1); chk("R6 bit2", thr_range, 1);

        // random mix
        for (int i = 0; i < 300; i++) begin
            hi = $urandom_range(0, 1);
            lo = $urandom_range(0, 1);
            ctl = 8'($urandom);
            for (int s = 0; s < 4; s++) begin
                bwr[s]  = 8'($urandom);
                thrr[s] = 8'($urandom);
            end
            step(4);
            check_all(bwr[slot_of(hi, lo)][7] ? "rand R3" : "rand R4");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule